// File: doc/BRIEF.md
# Three-Wire Ident-Clock-Data Bus Slave

This block is the slave end of a three-wire serial control bus made up of an Ident line, a Clock line and a shared Data line. It runs on a fast system clock. It oversamples the three bus lines through synchronizers and acts on the edges it sees in the synchronized copies. Each transfer opens with Ident low. While Ident is low, eight address bits arrive, least significant bit first. Ident then rises, and the slave compares the address with a table of local register addresses fixed by parameters. The table entry that matches sets the direction of the transfer and whether its data phase is one byte or two.

In a write, the slave shifts the data bits in, LSB first. It issues a single register-file write only when the master sends the short low pulse on Ident that closes the transfer, and only if exactly the expected number of bits arrived. In a read, the slave fetches the register with one cycle of latency, in the style of a block RAM. It then puts the value on Data, LSB first, by driving an open-drain pull-down enable while Clock is low. If the address matches no entry, the slave stays silent until the closing pulse.

Top module: `tri_wire_slave`

## Requirements
- R1: Address bits are taken on each rising edge of the bus Clock while Ident is low, eight of them, and the first bit is the least significant.
- R2: A write entry with a one-byte data phase produces one `wr_en` pulse of a single cycle, with `wr_idx` set to the entry index and `wr_data` set to the received byte in bits 7:0 and zero in bits 15:8.
- R3: A write entry with a two-byte data phase produces one `wr_en` pulse with the sixteen received bits in `wr_data`, and the first bit received lands in bit 0.
- R4: The write is issued only after Ident falls for the closing pulse. `wr_en` stays low from the last data bit until then, and it is never high while the synchronized Ident is high.
- R5: A read entry produces one `rd_en` pulse with `rd_idx` set to the entry index, and `rd_data` is sampled one cycle later. Each data bit is driven while Clock is low, LSB first, with `bus_data_oe`=1 meaning the line is pulled low (a 0 bit).
- R6: A two-byte read entry sends all sixteen bits of the fetched word, and a one-byte read entry sends bits 7:0.
- R7: If the address matches no table entry, the slave issues no write and no read and never asserts `bus_data_oe` during that transfer.
- R8: If the closing pulse comes before the expected number of data bits, or Ident rises after any address bit count other than eight, the transfer is discarded: no `wr_en` and no `rd_en` follow from it.
- R9: `bus_data_oe` is asserted only during the data phase of a matched read. It is released after the last expected bit and before the closing pulse.
- R10: After synchronous reset, `wr_en`, `rd_en` and `bus_data_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ident | input | 1 | Bus Ident line (low = address phase or closing pulse) |
| bus_clock | input | 1 | Bus Clock line, bits taken on its rising edge |
| bus_data | input | 1 | Sensed level of the shared Data line |
| bus_data_oe | output | 1 | Open-drain enable; 1 pulls Data low |
| wr_en | output | 1 | One-cycle register-file write strobe |
| wr_idx | output | IDX_W | Table index of the register written |
| wr_data | output | 16 | Write data, one-byte transfers zero-extended |
| rd_en | output | 1 | One-cycle register-file read strobe |
| rd_idx | output | IDX_W | Table index of the register read |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The assertions and the decoding logic rely on bus lines that move slowly compared with the system clock. Each level must be held for several system cycles, so that two synchronizer stages plus an edge register resolve every edge. They also rely on Ident never toggling in the same system cycle as a Clock edge, and on the master keeping Clock high whenever Ident changes. The bench keeps to these conditions by driving the bus from tasks. Each half period of the bus Clock lasts eight system cycles, and Ident changes only during a separate settle interval. Random addresses, data, short data phases and seven-bit address phases then vary only what is sent, never this timing.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int ADDR_BITS = 8;
  localparam int BYTE_BITS = 8;
  localparam int MAX_BITS  = 2 * BYTE_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_RD,
    ST_SKIP,
    ST_WAIT
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] lvl
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
    end else begin
      pipe[0] <= async_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign lvl = pipe[STAGES-1];
endmodule

// File: rtl/tws_addr_decode.sv
module tws_addr_decode #(
  parameter int                  N       = 4,
  parameter int                  IDX_W   = 2,
  parameter logic [N*8-1:0]      TABLE   = '0,
  parameter logic [N-1:0]        IS_RD   = '0,
  parameter logic [N-1:0]        IS_WIDE = '0
) (
  input  logic [7:0]       addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             rd,
  output logic             wide
);
  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = (addr == TABLE[g*8 +: 8]);
    end
  endgenerate

  // lowest index wins when two entries share an address
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    rd   = 1'b0;
    wide = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        rd   = IS_RD[i];
        wide = IS_WIDE[i];
      end
    end
  end
endmodule

// File: rtl/tri_wire_slave.sv
module tri_wire_slave
  import tws_pkg::*;
#(
  parameter int                      NUM_REGS    = 4,
  parameter logic [NUM_REGS*8-1:0]   REG_ADDRS   = 32'h4332_2110,
  parameter logic [NUM_REGS-1:0]     REG_READ    = 4'b1100,
  parameter logic [NUM_REGS-1:0]     REG_WIDE    = 4'b1010,
  parameter int                      SYNC_STAGES = 2,
  localparam int                     IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_ident,
  input  logic             bus_clock,
  input  logic             bus_data,
  output logic             bus_data_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [15:0]      wr_data,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [15:0]      rd_data
);
  localparam int CNT_W = $clog2(MAX_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] bus_s;
  logic       id_l, ck_l, dt_l;
  logic       id_d, ck_d;
  logic       id_rise, id_fall, ck_rise, ck_fall;

  tws_state_e       state;
  logic [7:0]       addr_sr;
  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] need;
  logic [15:0]      sh;
  logic             wide_q;
  logic [IDX_W-1:0] idx_q;
  logic             rd_load;

  logic             dec_hit, dec_rd, dec_wide;
  logic [IDX_W-1:0] dec_idx;

  tws_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({bus_data, bus_clock, bus_ident}),
    .lvl      (bus_s)
  );

  assign id_l = bus_s[0];
  assign ck_l = bus_s[1];
  assign dt_l = bus_s[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      id_d <= 1'b1;
      ck_d <= 1'b1;
    end else begin
      id_d <= id_l;
      ck_d <= ck_l;
    end
  end

  assign id_rise = id_l & ~id_d;
  assign id_fall = ~id_l & id_d;
  assign ck_rise = ck_l & ~ck_d;
  assign ck_fall = ~ck_l & ck_d;

  tws_addr_decode #(
    .N(NUM_REGS), .IDX_W(IDX_W), .TABLE(REG_ADDRS), .IS_RD(REG_READ), .IS_WIDE(REG_WIDE)
  ) u_dec (
    .addr (addr_sr),
    .hit  (dec_hit),
    .idx  (dec_idx),
    .rd   (dec_rd),
    .wide (dec_wide)
  );

  assign need = wide_q ? CNT_W'(MAX_BITS) : CNT_W'(BYTE_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_sr     <= '0;
      bit_cnt     <= '0;
      sh          <= '0;
      wide_q      <= 1'b0;
      idx_q       <= '0;
      rd_load     <= 1'b0;
      bus_data_oe <= 1'b0;
      wr_en       <= 1'b0;
      wr_idx      <= '0;
      wr_data     <= '0;
      rd_en       <= 1'b0;
      rd_idx      <= '0;
    end else begin
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      rd_load <= rd_en;
      case (state)
        ST_IDLE: begin
          if (id_fall) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            addr_sr <= '0;
          end
        end
        ST_ADDR: begin
          if (ck_rise) begin
            addr_sr <= {dt_l, addr_sr[7:1]};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
          end else if (id_rise) begin
            bit_cnt <= '0;
            if (bit_cnt == CNT_W'(ADDR_BITS) && dec_hit) begin
              idx_q  <= dec_idx;
              wide_q <= dec_wide;
              if (dec_rd) begin
                state  <= ST_RD;
                rd_en  <= 1'b1;
                rd_idx <= dec_idx;
              end else begin
                state <= ST_WR;
              end
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        ST_WR: begin
          if (ck_rise) begin
            sh <= {dt_l, sh[15:1]};
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
          end else if (id_fall) begin
            state <= ST_WAIT;
            if (bit_cnt == need) begin
              wr_en   <= 1'b1;
              wr_idx  <= idx_q;
              wr_data <= wide_q ? sh : {8'h00, sh[15:8]};
            end
          end
        end
        ST_RD: begin
          if (rd_load) sh <= rd_data;
          if (ck_fall) begin
            bus_data_oe <= (bit_cnt < need) ? ~sh[bit_cnt[3:0]] : 1'b0;
          end else if (ck_rise) begin
            if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt + 1'b1 >= need) bus_data_oe <= 1'b0;
          end else if (id_fall) begin
            bus_data_oe <= 1'b0;
            state       <= ST_WAIT;
          end
        end
        ST_SKIP: begin
          if (id_fall) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (id_rise) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tws_checker.sv
module tws_checker
  import tws_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic       oe,
  input logic       id_lvl,
  input tws_state_e state
);
  AST_WR_PULSE:  assert property (@(posedge clk) disable iff (rst) wr_en |=> !wr_en);                // R2
  AST_RD_PULSE:  assert property (@(posedge clk) disable iff (rst) rd_en |=> !rd_en);                // R5
  AST_WR_AT_END: assert property (@(posedge clk) disable iff (rst) wr_en |-> !id_lvl);               // R4
  AST_OE_READ:   assert property (@(posedge clk) disable iff (rst) oe |-> (state == ST_RD));         // R9
  AST_SKIP_MUTE: assert property (@(posedge clk) disable iff (rst) (state == ST_SKIP) |-> !oe);      // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(wr_en && rd_en));             // R5
endmodule

bind tri_wire_slave tws_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .oe     (bus_data_oe),
  .id_lvl (id_l),
  .state  (state)
);

// File: tb/test_tri_wire_slave.sv
module test_tri_wire_slave;
  localparam int          N     = 4;
  localparam logic [31:0] ADDRS = 32'h4332_2110;
  localparam logic [3:0]  RDS   = 4'b1100;
  localparam logic [3:0]  WIDES = 4'b1010;
  localparam int          T     = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id = 1'b1, cl = 1'b1, dt = 1'b1;
  logic line;
  logic oe, wr_en, rd_en;
  logic [1:0]  wr_idx, rd_idx;
  logic [15:0] wr_data, rd_data;
  logic [15:0] mem [N];

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [1:0]  last_widx, last_ridx;
  logic [15:0] last_wdata;
  logic oe_seen;
  int   wr_pre_end;
  logic oe_pre_end;
  bit   done = 0;

  always #5 clk = ~clk;

  assign line = dt & ~oe;

  tri_wire_slave #(.NUM_REGS(N), .REG_ADDRS(ADDRS), .REG_READ(RDS), .REG_WIDE(WIDES)) i_tri_wire_slave (
    .clk(clk), .rst(rst), .bus_ident(id), .bus_clock(cl), .bus_data(line),
    .bus_data_oe(oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_idx];
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en) begin wr_cnt++; last_widx = wr_idx; last_wdata = wr_data; end
      if (rd_en) begin rd_cnt++; last_ridx = rd_idx; end
      if (oe) oe_seen = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void lookup(input logic [7:0] a, output bit hit, output int idx,
                                 output bit rd, output bit wide);
    hit = 0; idx = 0; rd = 0; wide = 0;
    for (int i = N - 1; i >= 0; i--)
      if (ADDRS[i*8 +: 8] == a) begin hit = 1; idx = i; rd = RDS[i]; wide = WIDES[i]; end
  endfunction

  task automatic xfer(input logic [7:0] a, input int abits, input int dbits,
                      input logic [15:0] wv, output logic [15:0] rv);
    rv = '0;
    id = 1'b0; wt(T);
    for (int i = 0; i < abits; i++) begin
      cl = 1'b0; dt = a[i]; wt(T);
      cl = 1'b1; wt(T);
    end
    dt = 1'b1; id = 1'b1; wt(T);
    for (int i = 0; i < dbits; i++) begin
      cl = 1'b0; dt = wv[i]; wt(T);
      rv[i] = line;
      cl = 1'b1; wt(T);
    end
    dt = 1'b1; wt(T);
    wr_pre_end = wr_cnt; oe_pre_end = oe;
    id = 1'b0; wt(T);
    id = 1'b1; wt(2 * T);
  endtask

  task automatic run_case(input logic [7:0] a, input int abits, input int shrt, input logic [15:0] wv);
    bit hit, rd, wide; int idx, need, dbits, w0, r0;
    logic [15:0] rv, expw, mask;
    lookup(a, hit, idx, rd, wide);
    if (abits != 8) hit = 0;
    need  = wide ? 16 : 8;
    dbits = hit ? need - shrt : 8;
    w0 = wr_cnt; r0 = rd_cnt; oe_seen = 1'b0;
    xfer(a, abits, dbits, rd ? 16'hFFFF : wv, rv);
    if (!hit) begin
      chk(wr_cnt == w0 && rd_cnt == r0, abits != 8 ? "R8 bad addr length" : "R7 miss strobes", wr_cnt + rd_cnt, w0 + r0);
      chk(!oe_seen, "R7 miss oe", oe_seen, 0);
    end else if (!rd) begin
      chk(wr_pre_end == w0, "R4 no write before end pulse", wr_pre_end, w0);
      chk(!oe_seen, "R9 oe in write", oe_seen, 0);
      if (shrt != 0) chk(wr_cnt == w0, "R8 short write", wr_cnt, w0);
      else begin
        expw = wide ? wv : {8'h00, wv[7:0]};
        chk(wr_cnt == w0 + 1, wide ? "R3 write count" : "R2 write count", wr_cnt, w0 + 1);
        chk(last_widx == idx[1:0] && last_wdata == expw, wide ? "R3 write data" : "R2 write data",
            {last_widx, last_wdata}, {idx[1:0], expw});
      end
    end else begin
      chk(rd_cnt == r0 + 1 && last_ridx == idx[1:0], "R5 read strobe", {rd_cnt, last_ridx}, {r0 + 1, idx[1:0]});
      chk(wr_cnt == w0, "R5 no write on read", wr_cnt, w0);
      if (shrt == 0) begin
        mask = wide ? 16'hFFFF : 16'h00FF;
        chk((rv & mask) == (mem[idx] & mask), wide ? "R6 wide read bits" : "R5 read bits", rv & mask, mem[idx] & mask);
        chk(!oe_pre_end, "R9 oe released", oe_pre_end, 0);
      end
    end
  endtask

  initial begin
    int k;
    logic [7:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) mem[i] = 16'($urandom);
    wt(5);
    rst = 1'b0;
    wt(2);
    chk(!wr_en && !rd_en && !oe, "R10 reset outputs", {wr_en, rd_en, oe}, 0);
    run_case(8'h10, 8, 0, 16'h00A5);
    run_case(8'h21, 8, 0, 16'hBEEF);
    run_case(8'h32, 8, 0, 16'h0);
    run_case(8'h43, 8, 0, 16'h0);
    run_case(8'h08, 8, 0, 16'h005A);   // R1 bit-reversed 0x10 must miss
    run_case(8'h55, 8, 0, 16'h1234);
    run_case(8'h21, 8, 3, 16'h7777);
    run_case(8'h10, 8, 1, 16'h00FF);
    run_case(8'h10, 7, 0, 16'h0011);
    run_case(8'h21, 8, 0, 16'h8001);
    for (int n = 0; n < 40; n++) begin
      k = $urandom_range(0, 9);
      a = (k < 6) ? ADDRS[$urandom_range(0, N - 1) * 8 +: 8] : 8'($urandom);
      run_case(a, (k == 9) ? 7 : 8, (k == 8) ? $urandom_range(1, 3) : 0, 16'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule